// File: doc/BRIEF.md
# Step/Transition Chart Sequencer

This block advances a fixed chart of eight steps joined by eight guarded transitions. It follows the usual rules for charts of steps and transitions. Each step is either active or inactive, and several steps may be active together. A transition is considered only when every step feeding it is active. When a transition fires, its source steps are cleared and its destination steps are set in the same update. Updates happen only on clock edges where the scan strobe is high. Between strobes the step vector holds.

The chart runs as follows. The initial step 0 leads through transition T1 to a choice step, step 1. From there the left branch (T2 to step 2) is preferred over the right branch (T3 to step 3). Both branches merge into step 4, through T4 from step 2 or T5 from step 3. T6 then forks into two parallel branches. One branch is step 5, which moves through T7 to step 7. The other branch is step 6 alone. T8 joins steps 6 and 7 and returns to step 0.

A synchronous chart reset returns the chart to its initial step. Each step also has a one-clock entry pulse that a downstream action block can use to start work on entry.

Top module: `sfc_sequencer`

## Requirements
- R1: After the asynchronous reset, `step_active` is 8'h01 (only step 0), and `step_entry` is all zero.
- R2: On any clock edge with `chart_reset` high, `step_active` becomes 8'h01. This holds whatever the strobe and conditions are, and it overrides any transition that would otherwise fire.
- R3: On an edge where `scan_strobe` is low and `chart_reset` is low, `step_active` does not change.
- R4: A condition bit has no effect unless every source step of its transition is active. `cond[k]` belongs to transition T(k+1). The sources are: T1 step 0, T2 and T3 step 1, T4 step 2, T5 step 3, T6 step 4, T7 step 5, T8 steps 6 and 7.
- R5: When a transition fires on a strobed edge, its source steps clear and its destinations set in that same update. The destinations are: T1 step 1, T2 step 2, T3 step 3, T4 and T5 step 4, T6 steps 5 and 6, T7 step 7, T8 step 0.
- R6: With step 1 active and both `cond[1]` and `cond[2]` high on a strobe, only step 2 becomes active. Step 3 becomes active only when `cond[1]` is low and `cond[2]` is high.
- R7: T6 firing sets steps 5 and 6 together in one update.
- R8: T8 fires only when steps 6 and 7 are both active and `cond[7]` is high. An active step 7 without step 6, or step 6 without step 7, stays active.
- R9: `step_entry[i]` is high for exactly the one clock after an update in which step i went from inactive to active. This includes entry of step 0 by chart reset.
- R10: An active step whose outgoing conditions are all low stays active across any number of strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scan_strobe | input | 1 | Enables one chart update on this edge |
| chart_reset | input | 1 | Synchronous return to the initial step, highest priority |
| cond | input | 8 | Transition conditions, bit k for transition T(k+1) |
| step_active | output | 8 | Active flag per step |
| step_entry | output | 8 | One-clock pulse per step on entry |

## Verification
Two functions can meet in one cycle. The chart reset can arrive on the same strobed edge as an enabled transition. The left branch and the right branch of the selective choice can also both be true at once. The bench drives chart reset together with a firing condition and expects only step 0 active. It also raises both branch conditions at step 1 and expects step 2 alone. A long pseudo-random sweep then mixes strobes, resets and condition patterns. Each cycle is judged against a mask-driven model of the chart kept in the bench.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int NSTEP  = 8;
  localparam int NTRANS = 8;

  typedef logic [NSTEP-1:0]  step_vec_t;
  typedef logic [NTRANS-1:0] trans_vec_t;

  localparam step_vec_t INIT_STEPS = step_vec_t'(1);

  // Source steps of each transition (index = transition number minus one)
  localparam step_vec_t SRC_MASK [0:NTRANS-1] = '{
    8'h01, 8'h02, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'hC0
  };
  // Destination steps of each transition
  localparam step_vec_t DST_MASK [0:NTRANS-1] = '{
    8'h02, 8'h04, 8'h08, 8'h10, 8'h10, 8'h60, 8'h80, 8'h01
  };

  // Selective choice: the left transition blocks the right one
  localparam int SEL_LEFT  = 1;
  localparam int SEL_RIGHT = 2;
endpackage

// File: rtl/sfc_reset_sync.sv
module sfc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sfc_fire_logic.sv
module sfc_fire_logic
  import sfc_pkg::*;
(
  input  step_vec_t  active,
  input  logic       scan_strobe,
  input  trans_vec_t cond,
  output trans_vec_t fire
);
  trans_vec_t enabled;
  trans_vec_t raw_fire;

  for (genvar t = 0; t < NTRANS; t++) begin : g_trans
    // every source step must be active
    assign enabled[t]  = &(active | ~SRC_MASK[t]);
    assign raw_fire[t] = enabled[t] & cond[t] & scan_strobe;
  end

  always_comb begin
    fire = raw_fire;
    if (raw_fire[SEL_LEFT]) fire[SEL_RIGHT] = 1'b0;
  end
endmodule

// File: rtl/sfc_step_bank.sv
module sfc_step_bank
  import sfc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chart_reset,
  input  logic       scan_strobe,
  input  trans_vec_t fire,
  output step_vec_t  active,
  output step_vec_t  entry
);
  step_vec_t leave_v;
  step_vec_t arrive_v;
  step_vec_t active_d;
  step_vec_t entry_d;
  logic      update_en;

  always_comb begin
    leave_v  = '0;
    arrive_v = '0;
    for (int t = 0; t < NTRANS; t++) begin
      if (fire[t]) begin
        leave_v  = leave_v  | SRC_MASK[t];
        arrive_v = arrive_v | DST_MASK[t];
      end
    end
  end

  assign update_en = chart_reset | scan_strobe;

  always_comb begin
    if (chart_reset)      active_d = INIT_STEPS;
    else if (scan_strobe) active_d = (active & ~leave_v) | arrive_v;
    else                  active_d = active;
    entry_d = update_en ? (active_d & ~active) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= INIT_STEPS;
      entry  <= '0;
    end else begin
      if (update_en) active <= active_d;
      entry <= entry_d;
    end
  end

  p_reset_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
    chart_reset |=> (active == INIT_STEPS));

  p_hold_no_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_strobe && !chart_reset) |=> $stable(active));

  for (genvar s = 0; s < NSTEP; s++) begin : g_chk
    p_entry_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
      entry[s] |-> (active[s] && !$past(active[s])));
    p_entry_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      entry[s] |=> !entry[s]);
  end
endmodule

// File: rtl/sfc_sequencer.sv
module sfc_sequencer
  import sfc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_strobe,
  input  logic             chart_reset,
  input  logic [NTRANS-1:0] cond,
  output logic [NSTEP-1:0]  step_active,
  output logic [NSTEP-1:0]  step_entry
);
  logic       rst_sync_n;
  trans_vec_t fire;
  step_vec_t  active;
  step_vec_t  entry;

  sfc_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sfc_fire_logic u_fire (
    .active      (active),
    .scan_strobe (scan_strobe),
    .cond        (cond),
    .fire        (fire)
  );

  sfc_step_bank u_bank (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .chart_reset (chart_reset),
    .scan_strobe (scan_strobe),
    .fire        (fire),
    .active      (active),
    .entry       (entry)
  );

  assign step_active = active;
  assign step_entry  = entry;

  p_never_empty_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    step_active != '0);

  p_one_branch_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(step_active[2] && step_active[3]));

  p_fork_pair_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_active[4] && scan_strobe && cond[5] && !chart_reset)
      |=> (step_active[5] && step_active[6]));

  p_join_wait_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_active[7] && !step_active[6] && !chart_reset) |=> step_active[7]);

  p_inactive_ignored_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!step_active[4] && !step_active[5] && !step_active[6] && !chart_reset)
      |=> !step_active[5]);
endmodule

// File: tb/sfc_sequencer_test.sv
module sfc_sequencer_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       scan_strobe;
  logic       chart_reset;
  logic [7:0] cond;
  logic [7:0] step_active;
  logic [7:0] step_entry;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_act;
  logic [7:0] exp_ent;

  // chart description held by the bench
  logic [7:0] src_m [0:7];
  logic [7:0] dst_m [0:7];

  always #5 clk = ~clk;

  sfc_sequencer uut (
    .clk(clk), .rst_n(rst_n), .scan_strobe(scan_strobe),
    .chart_reset(chart_reset), .cond(cond),
    .step_active(step_active), .step_entry(step_entry)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] ent);
    checks++;
    if (step_active !== act || step_entry !== ent) begin
      errors++;
      $display("FAIL %s: active=%h entry=%h expected active=%h entry=%h",
               req, step_active, step_entry, act, ent);
    end
  endtask

  // advance bench model one edge
  task automatic model(input logic stb, input logic crst, input logic [7:0] c);
    logic [7:0] nxt, clr, set;
    logic left_taken;
    clr = '0; set = '0; left_taken = 1'b0;
    for (int t = 0; t < 8; t++) begin
      if (stb && c[t] && ((exp_act & src_m[t]) == src_m[t])
          && !(t == 2 && left_taken)) begin
        clr = clr | src_m[t];
        set = set | dst_m[t];
        if (t == 1) left_taken = 1'b1;
      end
    end
    if (crst)     nxt = 8'h01;
    else if (stb) nxt = (exp_act & ~clr) | set;
    else          nxt = exp_act;
    exp_ent = nxt & ~exp_act;
    exp_act = nxt;
  endtask

  // called at a falling edge; applies inputs for one rising edge
  task automatic cyc(input string req, input logic stb, input logic crst, input logic [7:0] c);
    scan_strobe = stb; chart_reset = crst; cond = c;
    @(negedge clk);
    model(stb, crst, c);
    check(req, exp_act, exp_ent);
  endtask

  initial begin
    src_m = '{8'h01, 8'h02, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'hC0};
    dst_m = '{8'h02, 8'h04, 8'h08, 8'h10, 8'h10, 8'h60, 8'h80, 8'h01};
    rst_n = 1'b0; scan_strobe = 1'b0; chart_reset = 1'b0; cond = '0;
    exp_act = 8'h01; exp_ent = 8'h00;
    repeat (3) @(negedge clk);
    check("R1", 8'h01, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", 8'h01, 8'h00);

    cyc("R10", 1, 0, 8'h00);                 // idle strobe holds step 0
    cyc("R4",  1, 0, 8'hFE);                 // all but T1: sources inactive
    cyc("R3",  0, 0, 8'h01);                 // T1 true without strobe
    cyc("R5",  1, 0, 8'h01);                 // T1 fires -> step 1
    check("R9", 8'h02, 8'h02);
    cyc("R9",  0, 0, 8'h00);                 // pulse drops after one clock
    cyc("R6",  1, 0, 8'h06);                 // both branches: left wins
    check("R6", 8'h04, 8'h04);
    cyc("R10", 1, 0, 8'h00);
    cyc("R5",  1, 0, 8'h08);                 // T4 -> step 4
    cyc("R7",  1, 0, 8'h20);                 // fork to 5 and 6
    check("R7", 8'h60, 8'h60);
    cyc("R8",  1, 0, 8'h80);                 // join blocked: step 7 inactive
    check("R8", 8'h60, 8'h00);
    cyc("R5",  1, 0, 8'h40);                 // T7 -> step 7
    cyc("R8",  1, 0, 8'h80);                 // join -> step 0
    check("R8", 8'h01, 8'h01);
    cyc("R5",  1, 0, 8'h01);
    cyc("R6",  1, 0, 8'h04);                 // right branch only
    check("R6", 8'h08, 8'h08);
    cyc("R5",  1, 0, 8'h10);                 // T5 -> step 4
    cyc("R2",  1, 1, 8'h20);                 // reset beats T6
    check("R2", 8'h01, 8'h01);
    cyc("R2",  0, 1, 8'h00);                 // reset while at step 0: no pulse
    check("R9", 8'h01, 8'h00);

    // pseudo-random sweep judged by the mask model
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc("R5", r[0] | r[1], (r[15:10] == 6'd0), r[23:16]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: active=%h entry=%h expected completion", step_active, step_entry);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule